// File: doc/BRIEF.md
# Four-Operation Single-Cycle Core

This block is a small processor that completes one instruction on every clock edge. It fetches a 16-bit word from a 256-entry program store, using an 8-bit program counter as the address. It decodes a 2-bit opcode and three 3-bit register selectors from that word. On the same edge it commits both the result and the next PC. It has eight 32-bit data registers. Two of them are fixed constants: index 0 always reads zero and index 1 always reads one. This means an unconditional branch is a conditional branch that tests register 0.

The program store is filled from outside through a plain write port while the core is held in reset. The core starts fetching at address 0 once reset is released. A combinational debug port returns any data register, and the current PC is visible at all times. A program ends by branching to its own address, so the PC then stays put.

Top module: `cpu4_core`

## Requirements
- R1: While rst_ni is low, the PC is 0 and data registers 2 to 7 read 0. Register 1 reads 1 and register 0 reads 0.
- R2: Opcode 00 (bits [15:14]) writes the 32-bit sum, modulo 2^32, of the registers selected by bits [13:11] and [10:8] into the register selected by bits [7:5]. Bits [4:0] have no effect on the result.
- R3: Opcode 01 replaces the register selected by bits [13:11] with its two's complement, modulo 2^32. Negating 0 gives 0 and negating 0x80000000 gives 0x80000000.
- R4: Opcode 10 writes the 8-bit value in bits [7:0], sign-extended to 32 bits, into the register selected by bits [13:11].
- R5: Opcode 11 with the register selected by bits [13:11] equal to zero loads the PC with bits [7:0] on the next edge.
- R6: Every other instruction, including opcode 11 when the tested register is nonzero, advances the PC by 1. The PC wraps from 255 to 0.
- R7: Writes aimed at register 0 or register 1 are discarded. Those registers keep reading 0 and 1.
- R8: Each instruction writes at most one data register: the one named by its destination selector. Opcode 11 writes none. Register indices held in unused fields, such as bits [7:5] of a load, are left untouched.
- R9: A write on the program port stores the word at the given address. The core runs that program from address 0 after reset is released.
- R10: A program loads 10, 0 and -1, then loops adding the counter into an accumulator and decrementing the counter until it reaches zero. It stops at a self-branch with 55 in the accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; holds the core idle |
| prog_we_i | input | 1 | Program store write strobe |
| prog_addr_i | input | 8 | Program store write address |
| prog_wdata_i | input | 16 | Program word to store |
| dbg_sel_i | input | 3 | Data register index for the debug read |
| dbg_data_o | output | 32 | Contents of the selected data register |
| pc_o | output | 8 | Current program counter |

## Verification
The bench builds 0x80000000 by doubling register 1 thirty-one times. It then negates that value and adds it to itself. A core that sign-handles negation, or that keeps a 33rd bit, leaves a nonzero result. The bench steps the PC one edge at a time through a taken branch, a branch that is not taken, and the wrap from 255 to 0. An off-by-one next-PC, or a PC that saturates, shows up as the wrong address. It sends writes to the constant registers. It also places register indices in fields that loads and branches ignore, to catch a decoder that enables the wrong register or writes during a branch. The summing loop checks the sign extension of -1 as well, because zero extension would make the loop run without ending.

// File: rtl/cpu4_pkg.sv
`timescale 1ns/1ps
package cpu4_pkg;
  localparam int INSN_W    = 16;
  localparam int REG_IDX_W = 3;
  localparam int NREG      = 2 ** REG_IDX_W;
  localparam int IMM_W     = 8;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_NEG = 2'b01,
    OP_LDI = 2'b10,
    OP_JIZ = 2'b11
  } op_e;

  // imm = {rd, pad}
  typedef struct packed {
    op_e                  op;
    logic [REG_IDX_W-1:0] ra;
    logic [REG_IDX_W-1:0] rb;
    logic [REG_IDX_W-1:0] rd;
    logic [4:0]           pad;
  } insn_t;
endpackage

// File: rtl/cpu4_regfile.sv
`timescale 1ns/1ps
module cpu4_regfile
  import cpu4_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [REG_IDX_W-1:0] waddr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [REG_IDX_W-1:0] raddr_a_i,
  input  logic [REG_IDX_W-1:0] raddr_b_i,
  input  logic [REG_IDX_W-1:0] raddr_d_i,
  output logic [DATA_W-1:0]    rdata_a_o,
  output logic [DATA_W-1:0]    rdata_b_o,
  output logic [DATA_W-1:0]    rdata_d_o
);
  logic [NREG-1:0][DATA_W-1:0] rd_vec;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i < 2) begin : g_const
      assign rd_vec[i] = DATA_W'(i);
    end else begin : g_store
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (we_i && waddr_i == REG_IDX_W'(i)) q <= wdata_i;
      end
      assign rd_vec[i] = q;
    end
  end

  assign rdata_a_o = rd_vec[raddr_a_i];
  assign rdata_b_o = rd_vec[raddr_b_i];
  assign rdata_d_o = rd_vec[raddr_d_i];

  // R8: a write to a storage register is visible on the next cycle
  a_r8_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i > REG_IDX_W'(1)) |=> rd_vec[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/cpu4_exec.sv
`timescale 1ns/1ps
module cpu4_exec
  import cpu4_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_W   = 8
) (
  input  insn_t                insn_i,
  input  logic [DATA_W-1:0]    a_val_i,
  input  logic [DATA_W-1:0]    b_val_i,
  input  logic [PC_W-1:0]      pc_i,
  output logic                 wr_en_o,
  output logic [REG_IDX_W-1:0] wr_idx_o,
  output logic [DATA_W-1:0]    wr_data_o,
  output logic [PC_W-1:0]      pc_next_o
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [IMM_W-1:0] imm;
  logic [PC_W-1:0]  pc_inc;

  assign imm    = {insn_i.rd, insn_i.pad};
  assign pc_inc = pc_i + 1'b1;

  always_comb begin
    wr_en_o   = 1'b0;
    wr_idx_o  = insn_i.ra;
    wr_data_o = '0;
    pc_next_o = pc_inc;
    unique case (insn_i.op)
      OP_ADD: begin
        wr_en_o   = 1'b1;
        wr_idx_o  = insn_i.rd;
        wr_data_o = a_val_i + b_val_i;
      end
      OP_NEG: begin
        wr_en_o   = 1'b1;
        wr_data_o = '0 - a_val_i;
      end
      OP_LDI: begin
        wr_en_o   = 1'b1;
        wr_data_o = {{EXT_W{imm[IMM_W-1]}}, imm};
      end
      OP_JIZ: begin
        if (a_val_i == '0) pc_next_o = PC_W'(imm);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cpu4_core.sv
`timescale 1ns/1ps
module cpu4_core
  import cpu4_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_W   = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 prog_we_i,
  input  logic [PC_W-1:0]      prog_addr_i,
  input  logic [INSN_W-1:0]    prog_wdata_i,
  input  logic [REG_IDX_W-1:0] dbg_sel_i,
  output logic [DATA_W-1:0]    dbg_data_o,
  output logic [PC_W-1:0]      pc_o
);
  localparam int PROG_DEPTH = 2 ** PC_W;

  logic [INSN_W-1:0]    prog_mem [PROG_DEPTH];
  logic [PC_W-1:0]      pc_q, pc_next;
  insn_t                insn;
  logic [DATA_W-1:0]    a_val, b_val, wr_data;
  logic [REG_IDX_W-1:0] wr_idx;
  logic                 wr_en;

  always_ff @(posedge clk_i) begin
    if (prog_we_i) prog_mem[prog_addr_i] <= prog_wdata_i;
  end

  assign insn = insn_t'(prog_mem[pc_q]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end

  cpu4_regfile #(.DATA_W(DATA_W)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_en),
    .waddr_i   (wr_idx),
    .wdata_i   (wr_data),
    .raddr_a_i (insn.ra),
    .raddr_b_i (insn.rb),
    .raddr_d_i (dbg_sel_i),
    .rdata_a_o (a_val),
    .rdata_b_o (b_val),
    .rdata_d_o (dbg_data_o)
  );

  cpu4_exec #(.DATA_W(DATA_W), .PC_W(PC_W)) u_exec (
    .insn_i    (insn),
    .a_val_i   (a_val),
    .b_val_i   (b_val),
    .pc_i      (pc_q),
    .wr_en_o   (wr_en),
    .wr_idx_o  (wr_idx),
    .wr_data_o (wr_data),
    .pc_next_o (pc_next)
  );

  assign pc_o = pc_q;

  a_r6_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn.op != OP_JIZ || a_val != '0) |=> pc_q == PC_W'($past(pc_q) + 1'b1));

  a_r5_jump_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn.op == OP_JIZ && a_val == '0) |=> pc_q == PC_W'($past({insn.rd, insn.pad})));

  a_r8_jump_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn.op == OP_JIZ) |-> !wr_en);

  a_r3_neg_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn.op == OP_NEG) |-> (DATA_W'(wr_data + a_val) == '0));

  a_r7_const_regs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_sel_i < REG_IDX_W'(2)) |-> dbg_data_o == DATA_W'(dbg_sel_i));
endmodule

// File: tb/tb_cpu4_core.sv
`timescale 1ns/1ps
module tb_cpu4_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_we = 1'b0;
  logic [7:0]  prog_addr = '0;
  logic [15:0] prog_wdata = '0;
  logic [2:0]  dbg_sel = '0;
  logic [31:0] dbg_data;
  logic [7:0]  pc;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  cpu4_core dut (
    .clk_i(clk), .rst_ni(rst_n), .prog_we_i(prog_we), .prog_addr_i(prog_addr),
    .prog_wdata_i(prog_wdata), .dbg_sel_i(dbg_sel), .dbg_data_o(dbg_data), .pc_o(pc)
  );

  function automatic logic [15:0] e_add(int a, int b, int d);
    return {2'b00, 3'(a), 3'(b), 3'(d), 5'b0};
  endfunction
  function automatic logic [15:0] e_neg(int a);
    return {2'b01, 3'(a), 11'b0};
  endfunction
  function automatic logic [15:0] e_ldi(int a, logic [7:0] v);
    return {2'b10, 3'(a), 3'b0, v};
  endfunction
  function automatic logic [15:0] e_jiz(int a, logic [7:0] t);
    return {2'b11, 3'(a), 3'b0, t};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
  endtask

  task automatic put(int addr, logic [15:0] w);
    prog_we = 1'b1; prog_addr = 8'(addr); prog_wdata = w;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic go();
    rst_n = 1'b1;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(int idx, output logic [31:0] v);
    dbg_sel = 3'(idx);
    #1;
    v = dbg_data;
  endtask

  // R9, R10
  task automatic t_sum();
    logic [31:0] v;
    int exp_sum = 0;
    for (int k = 1; k <= 10; k++) exp_sum += k;
    hold_reset();
    put(0, e_ldi(2, 8'd10));
    put(1, e_ldi(3, 8'd0));
    put(2, e_ldi(4, 8'hFF));
    put(3, e_add(2, 3, 3));
    put(4, e_add(2, 4, 2));
    put(5, e_jiz(2, 8'd7));
    put(6, e_jiz(0, 8'd3));
    put(7, e_jiz(0, 8'd7));
    go();
    step(80);
    check("R10 halt pc", {24'b0, pc}, 32'd7);
    rd(3, v); check("R10 accumulator", v, 32'(exp_sum));
    rd(2, v); check("R10 counter", v, 32'd0);
    rd(4, v); check("R9 loaded -1", v, 32'hFFFF_FFFF);
  endtask

  // R1
  task automatic t_reset();
    logic [31:0] v;
    hold_reset();
    #1;
    check("R1 pc", {24'b0, pc}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      rd(i, v);
      check("R1 reg", v, (i == 1) ? 32'd1 : 32'd0);
    end
  endtask

  // R2, R3: wraparound edges against a bench model
  task automatic t_arith();
    logic [31:0] v, m_pow, m_neg;
    int a = 0;
    hold_reset();
    put(a++, e_add(1, 0, 7));
    for (int k = 0; k < 31; k++) put(a++, e_add(7, 7, 7));
    put(a++, e_add(7, 0, 5));
    put(a++, e_neg(5));
    put(a++, e_add(7, 7, 6));
    put(a++, e_ldi(2, 8'hFF));
    put(a++, e_add(2, 1, 3));
    put(a++, e_ldi(4, 8'd5));
    put(a++, e_neg(4));
    put(a++, e_neg(0));
    put(a++, e_neg(3));
    put(a++, {2'b00, 3'd1, 3'd4, 3'd2, 5'b10101});
    put(a, e_jiz(0, 8'(a)));
    go();
    step(a + 5);
    m_pow = 32'd1;
    for (int k = 0; k < 31; k++) m_pow = m_pow + m_pow;
    m_neg = 32'd0 - m_pow;
    rd(7, v); check("R2 doubling", v, m_pow);
    rd(5, v); check("R3 neg of min", v, m_neg);
    rd(6, v); check("R2 carry out dropped", v, m_pow + m_pow);
    rd(3, v); check("R3 neg of zero", v, 32'd0);
    rd(4, v); check("R3 neg of five", v, 32'd0 - 32'd5);
    rd(2, v); check("R2 low bits ignored", v, 32'd1 + (32'd0 - 32'd5));
    check("R2 halt pc", {24'b0, pc}, 32'(a));
  endtask

  // R4, R7, R8
  task automatic t_load_const();
    logic [31:0] v;
    hold_reset();
    put(0, e_ldi(7, 8'd9));
    put(1, e_ldi(5, 8'h7F));
    put(2, e_ldi(6, 8'h80));
    put(3, e_add(1, 1, 0));
    put(4, e_add(1, 1, 1));
    put(5, e_neg(1));
    put(6, e_ldi(0, 8'h55));
    put(7, e_ldi(1, 8'h33));
    put(8, e_add(1, 1, 3));
    put(9, e_ldi(2, 8'hE0));
    put(10, e_jiz(1, 8'hE5));
    put(11, e_jiz(0, 8'd11));
    go();
    step(16);
    rd(5, v); check("R4 positive imm", v, 32'h0000_007F);
    rd(6, v); check("R4 negative imm", v, 32'hFFFF_FF80);
    rd(0, v); check("R7 reg0", v, 32'd0);
    rd(1, v); check("R7 reg1", v, 32'd1);
    rd(3, v); check("R7 reg1 read as one", v, 32'd2);
    rd(2, v); check("R8 load target", v, 32'hFFFF_FFE0);
    rd(7, v); check("R8 unused field untouched", v, 32'd9);
    check("R8 halt pc", {24'b0, pc}, 32'd11);
  endtask

  // R5, R6
  task automatic t_branch();
    logic [31:0] v;
    hold_reset();
    put(0, e_ldi(2, 8'd0));
    put(1, e_jiz(2, 8'd10));
    put(2, e_ldi(4, 8'h11));
    put(10, e_ldi(5, 8'd3));
    put(11, e_jiz(5, 8'd20));
    put(12, e_jiz(0, 8'd12));
    go();
    step(1); check("R6 pc after load", {24'b0, pc}, 32'd1);
    step(1); check("R5 taken", {24'b0, pc}, 32'd10);
    step(1); check("R6 after target", {24'b0, pc}, 32'd11);
    step(1); check("R6 not taken", {24'b0, pc}, 32'd12);
    step(1); check("R5 self halt", {24'b0, pc}, 32'd12);
    rd(4, v); check("R5 skipped word", v, 32'd0);
  endtask

  // R6 wrap
  task automatic t_wrap();
    logic [31:0] v;
    hold_reset();
    put(0, e_jiz(0, 8'd254));
    put(254, e_ldi(2, 8'd7));
    put(255, e_ldi(3, 8'd8));
    go();
    step(1); check("R6 jump far", {24'b0, pc}, 32'd254);
    step(1); check("R6 step", {24'b0, pc}, 32'd255);
    step(1); check("R6 wrap", {24'b0, pc}, 32'd0);
    rd(3, v); check("R6 last word ran", v, 32'd8);
  endtask

  initial begin
    step(3);
    t_sum();
    t_reset();
    t_arith();
    t_load_const();
    t_branch();
    t_wrap();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule